// File: doc/BRIEF.md
# Strip Word Corrector

This block sits behind a detector front end that delivers one byte per valid cycle. The bytes come in pairs: first a strip address byte, then the sample byte for that strip. Each byte has its own error flag. The block joins each pair into one 18-bit strip word. It looks the strip up in two per-strip tables. The first table marks dead strips, and words for those strips are discarded. The second table holds a compensated sample value, and that value replaces the raw sample byte of every live strip. Surviving words are queued in a first-in first-out buffer, which a downstream clustering stage drains.

Both tables are small synchronous RAMs. A host loads them through a plain address, data and write-enable port. A start-of-event pulse puts the byte pairing back in step at event boundaries. When the queue is full, words that arrive are lost, and a sticky flag records the loss.

Top module: `strip_word_corrector`

## Requirements
- R1: A queued word is laid out as {address error flag (bit 17), address (bits 16:9), sample error flag (bit 8), sample (bits 7:0)}. Both error flags are copied unchanged from the two input bytes.
- R2: Accepted bytes (byte_valid high) alternate between address and sample, starting with an address after reset. A word can only form when a sample byte completes a pair.
- R3: When evt_start is high, the pairing returns to the address phase. If a byte is accepted in the same cycle, that byte is taken as an address. An address byte whose sample never arrived produces no word.
- R4: When bit 0 of the dead-strip table entry for the pair's address is 1, the pair is discarded and nothing is queued.
- R5: For a live strip (table bit 0 is 0), the sample field of the queued word equals the compensation table entry at the pair's address, not the raw byte.
- R6: A sample byte accepted at clock edge t makes the word visible at the queue output after edge t+1, and not before.
- R7: The queue keeps arrival order. rd_data always shows the oldest word while fifo_empty is low. rd_en with a non-empty queue removes that word at the edge.
- R8: A word that arrives while fifo_full is high is discarded, even if a read happens in the same cycle. The overflow flag then goes high and stays high until reset.
- R9: After reset the queue is empty, fifo_full and overflow are low, and the pairing is in the address phase.
- R10: A table write at edge t does not affect a lookup made at edge t. It is used by every lookup made at a later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_start | input | 1 | Start-of-event pulse; realigns pairing |
| byte_valid | input | 1 | Stream byte present this cycle |
| byte_data | input | 8 | Stream byte (address or sample) |
| byte_err | input | 1 | Error flag of the stream byte |
| bad_we | input | 1 | Write enable for the dead-strip table |
| gain_we | input | 1 | Write enable for the compensation table |
| tbl_addr | input | 8 | Table write address (strip number) |
| tbl_wdata | input | 8 | Table write data (dead-strip table uses bit 0) |
| rd_en | input | 1 | Pop the oldest queued word |
| rd_data | output | 18 | Oldest queued word |
| fifo_empty | output | 1 | Queue holds no word |
| fifo_full | output | 1 | Queue is at capacity |
| overflow | output | 1 | Sticky: a word was lost to a full queue |

## Verification
The hardest situation to reach from the ports is a word arriving at a full queue in the same cycle that a read frees a slot. The stimulus gets there by writing more words than the queue holds while keeping reads off. It then sends one more pair and times rd_en so that the read lands on the edge where the word reaches the queue. Randomized phases mix in start-of-event pulses that land in the middle of a pair, and table writes that hit the strip being looked up in that same cycle. A bench model of the pairing, the tables and the queue predicts the result of every one of these cases.

// File: rtl/strip_pkg.sv
package strip_pkg;
    typedef enum logic {
        PH_ADDR = 1'b0,
        PH_SAMP = 1'b1
    } phase_e;
endpackage

// File: rtl/strip_lut_ram.sv
module strip_lut_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int ENTRIES = 1 << AW;

    logic [DW-1:0] mem [ENTRIES];
    logic [DW-1:0] rdata_q;

    // read returns the value held before a same-edge write
    always_ff @(posedge clk) begin
        if (re) rdata_q <= mem[raddr];
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/strip_pairer.sv
module strip_pairer
    import strip_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_start,
    input  logic          byte_valid,
    input  logic [BW-1:0] byte_data,
    input  logic          byte_err,
    output logic          lk_en,
    output logic [BW-1:0] lk_addr,
    output logic          pair_valid,
    output logic [BW-1:0] pair_addr,
    output logic          pair_aerr,
    output logic          pair_derr
);
    typedef struct packed {
        phase_e        phase;
        logic [BW-1:0] hold_addr;
        logic          hold_aerr;
        logic          pv;
        logic [BW-1:0] paddr;
        logic          paerr;
        logic          pderr;
    } pair_st_t;

    pair_st_t st_d, st_q;
    logic     samp_take;

    assign samp_take = byte_valid && !evt_start && (st_q.phase == PH_SAMP);

    always_comb begin
        st_d    = st_q;
        st_d.pv = 1'b0;
        if (byte_valid && (evt_start || st_q.phase == PH_ADDR)) begin
            st_d.hold_addr = byte_data;
            st_d.hold_aerr = byte_err;
            st_d.phase     = PH_SAMP;
        end else if (samp_take) begin
            st_d.pv    = 1'b1;
            st_d.paddr = st_q.hold_addr;
            st_d.paerr = st_q.hold_aerr;
            st_d.pderr = byte_err;
            st_d.phase = PH_ADDR;
        end else if (evt_start) begin
            st_d.phase = PH_ADDR;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lk_en      = samp_take;
    assign lk_addr    = st_q.hold_addr;
    assign pair_valid = st_q.pv;
    assign pair_addr  = st_q.paddr;
    assign pair_aerr  = st_q.paerr;
    assign pair_derr  = st_q.pderr;

    // R2: a completed pair needs a byte on the previous edge
    assert_pair_needs_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> $past(byte_valid));

    // R3: an event start never completes a pair
    assert_evt_no_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_start |=> !pair_valid);
endmodule

// File: rtl/strip_fifo.sv
module strip_fifo #(
    parameter int W     = 18,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full,
    output logic         overflow
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          ovf;
    } fifo_st_t;

    fifo_st_t     st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic         do_push, do_pop;

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (do_push) st_d.wp = st_q.wp + 1'b1;
        if (do_pop)  st_d.rp = st_q.rp + 1'b1;
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        if (push && full) st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wp] <= push_data;
    end

    assign head     = mem[st_q.rp];
    assign overflow = st_q.ovf;

    // R7: occupancy never exceeds capacity
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    // R8: overflow is sticky
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R8: a push into a full queue with a pop leaves it one below full
    assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && pop) |=> !full);
endmodule

// File: rtl/strip_word_corrector.sv
module strip_word_corrector #(
    parameter int BYTE_W     = 8,
    parameter int FIFO_DEPTH = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    evt_start,
    input  logic                    byte_valid,
    input  logic [BYTE_W-1:0]       byte_data,
    input  logic                    byte_err,
    input  logic                    bad_we,
    input  logic                    gain_we,
    input  logic [BYTE_W-1:0]       tbl_addr,
    input  logic [BYTE_W-1:0]       tbl_wdata,
    input  logic                    rd_en,
    output logic [2*BYTE_W+1:0]     rd_data,
    output logic                    fifo_empty,
    output logic                    fifo_full,
    output logic                    overflow
);
    localparam int WORD_W = 2 * (BYTE_W + 1);

    logic              lk_en;
    logic [BYTE_W-1:0] lk_addr;
    logic              pair_valid;
    logic [BYTE_W-1:0] pair_addr;
    logic              pair_aerr, pair_derr;
    logic [0:0]        bad_rd;
    logic [BYTE_W-1:0] gain_rd;
    logic              push;
    logic [WORD_W-1:0] word;

    strip_pairer #(.BW(BYTE_W)) u_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_start  (evt_start),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .byte_err   (byte_err),
        .lk_en      (lk_en),
        .lk_addr    (lk_addr),
        .pair_valid (pair_valid),
        .pair_addr  (pair_addr),
        .pair_aerr  (pair_aerr),
        .pair_derr  (pair_derr)
    );

    strip_lut_ram #(.AW(BYTE_W), .DW(1)) u_bad (
        .clk   (clk),
        .we    (bad_we),
        .waddr (tbl_addr),
        .wdata (tbl_wdata[0:0]),
        .re    (lk_en),
        .raddr (lk_addr),
        .rdata (bad_rd)
    );

    strip_lut_ram #(.AW(BYTE_W), .DW(BYTE_W)) u_gain (
        .clk   (clk),
        .we    (gain_we),
        .waddr (tbl_addr),
        .wdata (tbl_wdata),
        .re    (lk_en),
        .raddr (lk_addr),
        .rdata (gain_rd)
    );

    always_comb begin
        push = pair_valid && !bad_rd[0];
        word = {pair_aerr, pair_addr, pair_derr, gain_rd};
    end

    strip_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (word),
        .pop       (rd_en),
        .head      (rd_data),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .overflow  (overflow)
    );

    // R4: a dead strip into an idle empty queue leaves it empty
    assert_drop_bad_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && bad_rd[0] && fifo_empty) |=> fifo_empty);

    // R6: a live pair lands in the queue at the next edge
    assert_land_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && !bad_rd[0] && !fifo_full) |=> !fifo_empty);
endmodule

// File: tb/sim_strip_word_corrector.sv
module sim_strip_word_corrector;
    localparam int CLK_PERIOD = 10;
    localparam int BW = 8;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_start = 0, byte_valid = 0, byte_err = 0;
    logic [BW-1:0] byte_data = '0;
    logic bad_we = 0, gain_we = 0, rd_en = 0;
    logic [BW-1:0] tbl_addr = '0, tbl_wdata = '0;
    logic [17:0] rd_data;
    logic fifo_empty, fifo_full, overflow;

    always #(CLK_PERIOD/2) clk = ~clk;

    strip_word_corrector #(.BYTE_W(BW), .FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .byte_valid(byte_valid),
        .byte_data(byte_data), .byte_err(byte_err), .bad_we(bad_we), .gain_we(gain_we),
        .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .rd_en(rd_en), .rd_data(rd_data),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full), .overflow(overflow)
    );

    int nchk = 0, nfail = 0;

    // bench model
    logic          bad_m [256];
    logic [BW-1:0] gain_m [256];
    logic [17:0]   q_m [$];
    logic          ph_m = 0;
    logic [BW-1:0] ha_m = '0;
    logic          he_m = 0;
    logic          pend_v = 0;
    logic [17:0]   pend_w = '0;
    logic          ovf_m = 0;

    function automatic logic [17:0] mk_word(logic ae, logic [7:0] a, logic de, logic [7:0] d);
        return {ae, a, de, d};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R7 fifo_empty", 32'(fifo_empty), 32'(q_m.size() == 0));
        chk("R8 fifo_full", 32'(fifo_full), 32'(q_m.size() == DEPTH));
        chk("R8 overflow", 32'(overflow), 32'(ovf_m));
        if (q_m.size() > 0) chk("R1 R5 R7 rd_data", 32'(rd_data), 32'(q_m[0]));
    endtask

    task automatic model_edge();
        logic          np;
        logic [17:0]   nw;
        int            sz;
        sz = q_m.size();
        if (pend_v && sz == DEPTH) ovf_m = 1;
        if (rd_en && sz > 0) void'(q_m.pop_front());
        if (pend_v && sz < DEPTH) q_m.push_back(pend_w);
        np = 0; nw = '0;
        if (byte_valid && (evt_start || !ph_m)) begin
            ha_m = byte_data; he_m = byte_err; ph_m = 1;
        end else if (byte_valid) begin
            if (!bad_m[ha_m]) begin
                np = 1; nw = mk_word(he_m, ha_m, byte_err, gain_m[ha_m]);
            end
            ph_m = 0;
        end else if (evt_start) begin
            ph_m = 0;
        end
        pend_v = np; pend_w = nw;
        if (bad_we)  bad_m[tbl_addr]  = tbl_wdata[0];
        if (gain_we) gain_m[tbl_addr] = tbl_wdata;
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all();
    endtask

    task automatic idle();
        evt_start = 0; byte_valid = 0; byte_err = 0; bad_we = 0; gain_we = 0; rd_en = 0;
    endtask

    task automatic send(logic [7:0] b, logic e, logic ev);
        idle(); byte_valid = 1; byte_data = b; byte_err = e; evt_start = ev; cyc();
    endtask

    task automatic wr_tbl(logic [7:0] a, logic bad, logic [7:0] g);
        idle(); bad_we = 1; gain_we = 1; tbl_addr = a; tbl_wdata = g;
        tbl_wdata[0] = tbl_wdata[0];
        cyc();
        idle(); bad_we = 1; tbl_addr = a; tbl_wdata = {7'd0, bad}; cyc();
    endtask

    task automatic drain();
        while (q_m.size() > 0) begin idle(); rd_en = 1; cyc(); end
        idle(); cyc(); cyc();
        while (q_m.size() > 0) begin idle(); rd_en = 1; cyc(); end
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5a17));
        for (int i = 0; i < 256; i++) begin bad_m[i] = 0; gain_m[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R9 reset state
        chk("R9 empty after reset", 32'(fifo_empty), 32'd1);
        chk("R9 full after reset", 32'(fifo_full), 32'd0);
        chk("R9 overflow after reset", 32'(overflow), 32'd0);

        // load tables: one write per edge for each table
        for (int i = 0; i < 256; i++) begin
            idle(); bad_we = 1; gain_we = 1; tbl_addr = 8'(i);
            tbl_wdata = 8'($urandom);
            cyc();
            gain_m[i] = gain_m[i];
        end
        for (int i = 0; i < 256; i++) begin
            idle(); bad_we = 1; tbl_addr = 8'(i);
            tbl_wdata = {7'd0, ($urandom % 8) == 0};
            cyc();
        end

        // R1 R2 R6: directed pair with address error flag
        wr_tbl(8'h05, 1'b0, 8'h3C);
        send(8'h05, 1'b1, 1'b0);
        send(8'hA7, 1'b0, 1'b0);
        chk("R6 not yet visible", 32'(fifo_empty), 32'd1);
        idle(); cyc();
        chk("R6 visible after second edge", 32'(fifo_empty), 32'd0);
        chk("R1 R5 word layout", 32'(rd_data), 32'(mk_word(1'b1, 8'h05, 1'b0, 8'h3C)));
        drain();

        // R4: dead strip dropped
        wr_tbl(8'h11, 1'b1, 8'h77);
        send(8'h11, 1'b0, 1'b0);
        send(8'h22, 1'b1, 1'b0);
        idle(); cyc(); cyc();
        chk("R4 dead strip not queued", 32'(fifo_empty), 32'd1);

        // R3: event start mid-pair realigns to address
        wr_tbl(8'h30, 1'b0, 8'h99);
        wr_tbl(8'h31, 1'b0, 8'h42);
        send(8'h30, 1'b0, 1'b0);
        send(8'h31, 1'b0, 1'b1);
        send(8'hEE, 1'b1, 1'b0);
        idle(); cyc();
        chk("R3 address taken at evt_start", 32'(rd_data), 32'(mk_word(1'b0, 8'h31, 1'b1, 8'h42)));
        send(8'h30, 1'b0, 1'b0);
        idle(); evt_start = 1; cyc();
        send(8'h31, 1'b0, 1'b0);
        send(8'h01, 1'b0, 1'b0);
        idle(); cyc();
        chk("R3 dangling address dropped", 32'(q_m.size()), 32'd2);
        drain();

        // R10: table write on the lookup edge uses old value
        wr_tbl(8'h40, 1'b0, 8'h10);
        send(8'h40, 1'b0, 1'b0);
        idle(); byte_valid = 1; byte_data = 8'h00; gain_we = 1; tbl_addr = 8'h40; tbl_wdata = 8'h20; cyc();
        idle(); cyc();
        chk("R10 same-edge write not seen", 32'(rd_data[7:0]), 32'h10);
        send(8'h40, 1'b0, 1'b0);
        send(8'h00, 1'b0, 1'b0);
        idle(); rd_en = 1; cyc();
        chk("R10 later lookup sees write", 32'(rd_data[7:0]), 32'h20);
        drain();

        // R8: fill, overflow, and push while full with pop
        wr_tbl(8'h50, 1'b0, 8'h5A);
        for (int i = 0; i < DEPTH + 1; i++) begin
            send(8'h50, 1'b0, 1'b0);
            send(8'(i), 1'b0, 1'b0);
        end
        idle(); cyc(); cyc();
        chk("R8 full reached", 32'(fifo_full), 32'd1);
        chk("R8 overflow set", 32'(overflow), 32'd1);
        send(8'h50, 1'b0, 1'b0);
        send(8'h00, 1'b0, 1'b0);
        idle(); rd_en = 1; cyc();
        chk("R8 push dropped while full", 32'(fifo_full), 32'd0);
        drain();
        chk("R8 overflow sticky", 32'(overflow), 32'd1);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            idle();
            byte_valid = ($urandom % 10) < 7;
            byte_data  = 8'($urandom);
            byte_err   = ($urandom % 6) == 0;
            evt_start  = ($urandom % 30) == 0;
            rd_en      = ($urandom % 2) == 0;
            if (($urandom % 20) == 0) begin
                tbl_addr = 8'($urandom); tbl_wdata = 8'($urandom);
                if ($urandom % 2) bad_we = 1; else gain_we = 1;
            end
            cyc();
        end
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule